// File: doc/BRIEF.md
# Address-Sequence Block Write Protection Unit

This unit watches the stream of accesses made to a 32K x 8 memory and recognises fixed command sequences that are encoded purely as read addresses. A correct run of seven reads turns whole-array protection off. The same run with a different last address turns it back on. An optional eighth access to a reserved address either loads a new eight-bit block map or recalls the map already held. The unit then switches to per-block protection, where each bit covers one 4K region.

For every access the unit drives a write-inhibit flag that the memory controller uses to suppress the cell write. When the eighth access is a read, the unit also raises a substitute flag so that the controller returns the map byte in place of the array data. The map register keeps its value through reset, as nonvolatile storage would. Reset only returns the unit to whole-array protection.

Top module: `blkprot_unit`

## Requirements
- R1: After reset, `wr_inhibit` is 1 for every address.
- R2: Seven consecutive reads at hex 1823, 1820, 1822, 0418, 041B, 0419, 041A, in that order, clear protection so that `wr_inhibit` is 0 for every address.
- R3: The first six reads of that run, followed by a read at hex 040A, restore whole-array protection (`wr_inhibit` 1 everywhere).
- R4: Any access that is not the next expected step returns the matcher to its start. That same access counts as a first step if it is a read at hex 1823. Writes never advance the matcher.
- R5: A write at hex 040F right after the seven-read disable run loads `acc_wdata` into `prot_map`, and `wr_inhibit` is 1 for that access. At no other time does `prot_map` change.
- R6: A read at hex 040F right after the disable run asserts `map_rd_sub` for that access with `map_rd_data` equal to `prot_map`, and leaves the map unchanged.
- R7: After either eighth access, block mode starts only at the next `cyc_end` pulse. Until then protection stays cleared.
- R8: In block mode, `wr_inhibit` equals `prot_map[acc_addr[14:12]]`, where 1 blocks writes. A map of 8'b10011000 blocks regions 3, 4 and 7.
- R9: Reset does not change `prot_map`. After reset, a restore run brings back the map held before the reset.
- R10: `map_rd_sub` is 0 on every access other than the R6 read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| acc_valid | input | 1 | One-cycle strobe: an access has latched its address |
| acc_addr | input | 15 | Latched access address |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_wdata | input | 8 | Write data of the access |
| cyc_end | input | 1 | End of access cycle (chip-enable rising) |
| wr_inhibit | output | 1 | Suppress the memory write for `acc_addr` |
| map_rd_sub | output | 1 | Return `map_rd_data` in place of array data |
| map_rd_data | output | 8 | Map byte for substitution |
| prot_map | output | 8 | Current block-protect map |

## Verification
The bench builds the unit with its default widths, a 15-bit address and an 8-bit map, so that eight 4K regions are selected by the top three address bits. These are the exact addresses of the command sequences. At these sizes, directed runs can reach every region boundary (0x2FFF/0x3000, 0x4FFF/0x5000), broken and restarted sequences, and the pending window before `cyc_end`. A seeded random stream biased toward the next expected step completes and aborts many sequences, and the result of every access is compared with a model in the bench.

// File: rtl/blkprot_unit.sv
module blkprot_unit #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              cyc_end,
  output logic              wr_inhibit,
  output logic              map_rd_sub,
  output logic [DATA_W-1:0] map_rd_data,
  output logic [DATA_W-1:0] prot_map
);
  localparam int BSEL_W = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] A_S0  = ADDR_W'(15'h1823);
  localparam logic [ADDR_W-1:0] A_S1  = ADDR_W'(15'h1820);
  localparam logic [ADDR_W-1:0] A_S2  = ADDR_W'(15'h1822);
  localparam logic [ADDR_W-1:0] A_S3  = ADDR_W'(15'h0418);
  localparam logic [ADDR_W-1:0] A_S4  = ADDR_W'(15'h041B);
  localparam logic [ADDR_W-1:0] A_S5  = ADDR_W'(15'h0419);
  localparam logic [ADDR_W-1:0] A_OFF = ADDR_W'(15'h041A);
  localparam logic [ADDR_W-1:0] A_ON  = ADDR_W'(15'h040A);
  localparam logic [ADDR_W-1:0] A_MAP = ADDR_W'(15'h040F);
  localparam logic [1:0] M_ALL = 2'd0, M_NONE = 2'd1, M_BLOCK = 2'd2;

  logic [2:0] step_q;
  logic [1:0] mode_q;
  logic       pend_q;
  logic [DATA_W-1:0] map_q;

  logic is_rd, first_hit, step_ok, map_hit;
  logic [ADDR_W-1:0] want_addr;
  logic [BSEL_W-1:0] blk_sel;

  assign is_rd     = acc_valid && !acc_write;
  assign first_hit = is_rd && acc_addr == A_S0;
  assign map_hit   = step_q == 3'd7 && acc_addr == A_MAP;
  assign blk_sel   = acc_addr[ADDR_W-1 -: BSEL_W];

  always_comb begin
    case (step_q)
      3'd0:    want_addr = A_S0;
      3'd1:    want_addr = A_S1;
      3'd2:    want_addr = A_S2;
      3'd3:    want_addr = A_S3;
      3'd4:    want_addr = A_S4;
      default: want_addr = A_S5;
    endcase
    step_ok = is_rd && step_q < 3'd6 && acc_addr == want_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= 3'd0;
      mode_q <= M_ALL;
      pend_q <= 1'b0;
    end else begin
      if (acc_valid) begin
        if (map_hit) begin
          pend_q <= 1'b1;
          step_q <= 3'd0;
        end else if (is_rd && step_q == 3'd6 && acc_addr == A_OFF) begin
          mode_q <= M_NONE;
          pend_q <= 1'b0;
          step_q <= 3'd7;
        end else if (is_rd && step_q == 3'd6 && acc_addr == A_ON) begin
          mode_q <= M_ALL;
          pend_q <= 1'b0;
          step_q <= 3'd0;
        end else if (step_ok) begin
          step_q <= step_q + 3'd1;
        end else begin
          step_q <= first_hit ? 3'd1 : 3'd0;
        end
      end
      if (cyc_end && pend_q) begin
        mode_q <= M_BLOCK;
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk)
    if (rst_n && acc_valid && acc_write && map_hit) map_q <= acc_wdata;

  assign wr_inhibit  = map_hit || mode_q == M_ALL || (mode_q == M_BLOCK && map_q[blk_sel]);
  assign map_rd_sub  = is_rd && map_hit;
  assign map_rd_data = map_q;
  assign prot_map    = map_q;
endmodule

// File: rtl/blkprot_unit_chk.sv
module blkprot_unit_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_write,
  input logic              cyc_end,
  input logic              wr_inhibit,
  input logic              map_rd_sub,
  input logic [DATA_W-1:0] prot_map,
  input logic [2:0]        step_q,
  input logic [1:0]        mode_q
);
  localparam logic [ADDR_W-1:0] A_OFF = ADDR_W'(15'h041A);
  localparam logic [ADDR_W-1:0] A_ON  = ADDR_W'(15'h040A);
  localparam logic [1:0] M_ALL = 2'd0, M_NONE = 2'd1, M_BLOCK = 2'd2;

  p_all_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == M_ALL |-> wr_inhibit);
  p_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && step_q == 3'd6 && acc_addr == A_OFF) |=> (mode_q == M_NONE && step_q == 3'd7));
  p_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && step_q == 3'd6 && acc_addr == A_ON) |=> (mode_q == M_ALL && step_q == 3'd0));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(step_q));
  p_map_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |=> $stable(prot_map));
  p_sub_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    map_rd_sub |-> (acc_valid && !acc_write));
  p_block_on_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != M_BLOCK |=> (mode_q != M_BLOCK || $past(cyc_end)));
endmodule

bind blkprot_unit blkprot_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_write(acc_write), .cyc_end(cyc_end), .wr_inhibit(wr_inhibit),
  .map_rd_sub(map_rd_sub), .prot_map(prot_map), .step_q(step_q), .mode_q(mode_q)
);

// File: tb/blkprot_unit_bench.sv
module blkprot_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, cyc_end = 1'b0;
  logic [14:0] acc_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic wr_inhibit, map_rd_sub;
  logic [7:0] map_rd_data, prot_map;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  int m_step = 0, m_mode = 0;  // mode 0 all, 1 none, 2 block
  bit m_pend = 0;
  logic [7:0] m_map = '0;

  always #5 clk = ~clk;

  blkprot_unit u_blkprot_unit (.*);

  function automatic logic [14:0] seq_at(int i);
    case (i)
      0: return 15'h1823; 1: return 15'h1820; 2: return 15'h1822;
      3: return 15'h0418; 4: return 15'h041B; 5: return 15'h0419;
      6: return 15'h041A; 7: return 15'h040A; default: return 15'h040F;
    endcase
  endfunction

  function automatic bit m_inhibit(logic [14:0] a);
    if (m_step == 7 && a == 15'h040F) return 1'b1;
    if (m_mode == 0) return 1'b1;
    if (m_mode == 2) return m_map[a[14:12]];
    return 1'b0;
  endfunction

  function automatic bit m_sub(logic [14:0] a, bit w);
    return !w && m_step == 7 && a == 15'h040F;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic m_update(logic [14:0] a, bit w, logic [7:0] d);
    bit rd = !w;
    if (m_step == 7 && a == 15'h040F) begin
      m_pend = 1; m_step = 0; if (w) m_map = d;
    end else if (rd && m_step == 6 && a == 15'h041A) begin
      m_mode = 1; m_pend = 0; m_step = 7;
    end else if (rd && m_step == 6 && a == 15'h040A) begin
      m_mode = 0; m_pend = 0; m_step = 0;
    end else if (rd && m_step < 6 && a == seq_at(m_step)) m_step++;
    else m_step = (rd && a == 15'h1823) ? 1 : 0;
  endtask

  task automatic access(logic [14:0] a, bit w, logic [7:0] d, string tag);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_write = w; acc_wdata = d;
    #1;
    check({tag, " inhibit"}, wr_inhibit, m_inhibit(a));
    check("R10 sub", map_rd_sub, m_sub(a, w));
    if (m_sub(a, w)) check("R6 data", map_rd_data, m_map);
    @(negedge clk);
    acc_valid = 0; acc_write = 0; cyc_end = 1;
    m_update(a, w, d);
    @(negedge clk);
    cyc_end = 0;
    if (m_pend) begin m_mode = 2; m_pend = 0; end
  endtask

  task automatic probe(logic [14:0] a, bit exp, string tag);
    @(negedge clk);
    acc_addr = a; #1;
    check(tag, wr_inhibit, exp);
  endtask

  task automatic prefix6();
    for (int i = 0; i < 6; i++) access(seq_at(i), 0, 8'h00, "R4");
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_step = 0; m_mode = 0; m_pend = 0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    do_reset();
    // R1 reset state
    probe(15'h0000, 1, "R1");
    probe(15'h7FFF, 1, "R1");
    check("R10 idle sub", map_rd_sub, 0);
    // R2 disable
    prefix6(); access(15'h041A, 0, 0, "R2");
    probe(15'h0000, 0, "R2"); probe(15'h7FFF, 0, "R2");
    // R3 enable
    prefix6(); access(15'h040A, 0, 0, "R3");
    probe(15'h3000, 1, "R3");
    // R4 broken run stays protected
    access(15'h1823, 0, 0, "R4"); access(15'h1820, 0, 0, "R4");
    access(15'h5555, 0, 0, "R4");
    for (int i = 2; i < 6; i++) access(seq_at(i), 0, 0, "R4");
    access(15'h041A, 0, 0, "R4");
    probe(15'h1000, 1, "R4");
    // R4 write breaks the run
    access(15'h1823, 0, 0, "R4"); access(15'h1820, 1, 8'h11, "R4");
    for (int i = 2; i < 6; i++) access(seq_at(i), 0, 0, "R4");
    access(15'h041A, 0, 0, "R4");
    probe(15'h1000, 1, "R4");
    // R4 mismatch retried as first step
    access(15'h1823, 0, 0, "R4");
    prefix6(); access(15'h041A, 0, 0, "R4");
    probe(15'h1000, 0, "R4");
    // R5/R7/R8 load map 10011000
    prefix6(); access(15'h041A, 0, 0, "R2");
    @(negedge clk);
    acc_valid = 1; acc_addr = 15'h040F; acc_write = 1; acc_wdata = 8'b1001_1000;
    #1;
    check("R5 inhibit on map write", wr_inhibit, 1);
    check("R10 sub on write", map_rd_sub, 0);
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    m_update(15'h040F, 1, 8'b1001_1000);
    check("R5 map", prot_map, 8'h98);
    probe(15'h3000, 0, "R7 pending");
    @(negedge clk); cyc_end = 1; @(negedge clk); cyc_end = 0;
    m_mode = 2; m_pend = 0;
    probe(15'h3000, 1, "R8"); probe(15'h4FFF, 1, "R8");
    probe(15'h7000, 1, "R8"); probe(15'h0000, 0, "R8");
    probe(15'h2FFF, 0, "R8"); probe(15'h5000, 0, "R8");
    // R9 reset keeps map
    do_reset();
    check("R9 map kept", prot_map, 8'h98);
    probe(15'h0000, 1, "R9");
    // R6 restore read
    prefix6(); access(15'h041A, 0, 0, "R2");
    access(15'h040F, 0, 0, "R6");
    check("R6 map unchanged", prot_map, 8'h98);
    probe(15'h3000, 1, "R9"); probe(15'h1000, 0, "R9");
    // random phase
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom % 10;
      logic [14:0] a;
      bit w;
      if (r < 6) begin
        if (m_step < 6) a = seq_at(m_step);
        else if (m_step == 6) a = seq_at(($urandom % 4 == 0) ? 7 : 6);
        else a = 15'h040F;
      end else if (r < 8) a = 15'($urandom);
      else a = seq_at($urandom % 9);
      w = (m_step == 7 && a == 15'h040F) ? bit'($urandom % 2) : ($urandom % 10 == 0);
      access(a, w, 8'($urandom), "R8");
      if (k % 500 == 499) begin
        do_reset();
        check("R9 random reset", prot_map, m_map);
      end
    end
    check("R5 final map", prot_map, m_map);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule